// File: doc/BRIEF.md
# Parity-Protected SPI Frame Transceiver

This block is a 16-bit SPI master for a register-addressed peripheral. A client hands it one request at a time over a valid/ready handshake: either a write, which carries a 5-bit register address and an 8-bit value, or a read, which carries a 5-bit target sub-address. The block builds the outgoing word and sets the low bit so that the word has odd parity. It generates SCLK and frames the word with an active-low chip select, shifting it out MSB first in SPI mode 1 while it captures the 16-bit answer.

The peripheral answers each frame with data that belongs to the frame before it. For that reason, the block judges every answer against the sub-address it remembers from the previous request. If the previous request was not a read, it skips the address check. Each request ends with a one-cycle completion pulse. The pulse carries the raw answer and a 2-bit verdict. Three saturating counters record rejected answers by cause.

A request can be marked as a continuation of the current burst. Once an answer in a burst has failed, every continuation request is completed at once as skipped, and no frame goes on the wire. The next request that is not marked as a continuation starts a new burst.

Top module: `spi_frame_xcvr`

## Requirements
- R1: A write request sends a word with the address in bits 14:10 and the data in bits 8:1. Bits 15 and 9 are 0.
- R2: Bit 0 of every transmitted word is chosen so that the 16-bit word has an odd number of ones.
- R3: A read request sends address 0x10 in bits 14:10 and the sub-address in bits 5:1. Bits 15, 9 and 8:6 are 0.
- R4: SCLK idles low. MOSI changes on rising SCLK edges and MISO is sampled on falling edges, MSB first. cs_n is low for exactly 16 SCLK cycles per frame and stays high for at least 2 clocks between frames.
- R5: req_ready is low while a frame is in progress. Every accepted request gives exactly one single-cycle rsp_valid pulse, and rsp_data holds the captured answer.
- R6: An answer with an even number of ones gets rsp_status 1 and increments cnt_parity.
- R7: An answer with odd parity and bit 15 set gets rsp_status 2 and increments cnt_frame.
- R8: If the previous transmitted frame was a read, an answer with correct parity and bit 15 clear must have bit 9 set and bits 14:10 equal to that sub-address. Otherwise it gets rsp_status 3 and increments cnt_mismatch. A passing answer gets rsp_status 0.
- R9: After a transmitted write, the next answer is not address-checked.
- R10: When req_cont is 1 and an earlier answer in the current burst failed, the request completes with rsp_skipped=1 and rsp_status 0. No chip-select assertion occurs and the address-check state is unchanged. A request with req_cont=0 starts a new burst.
- R11: After synchronous reset, all counters are 0 and no address check is pending, so the first answer is not address-checked.
- R12: Each counter saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_is_read | input | 1 | 1 = read request, 0 = write |
| req_cont | input | 1 | Request continues the current burst |
| req_addr | input | 5 | Register address (write) or sub-address (read) |
| req_data | input | 8 | Write value |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Raw captured answer |
| rsp_status | output | 2 | 0 ok, 1 parity, 2 frame error, 3 address mismatch |
| rsp_skipped | output | 1 | Request dropped by a failed burst |
| cnt_parity | output | CNT_W | Parity error count |
| cnt_frame | output | CNT_W | Frame error count |
| cnt_mismatch | output | CNT_W | Address mismatch count |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The two behaviours that share a cycle are the verdict on an answer and the update of the remembered sub-address. When a frame ends, the answer is judged against the old sub-address while the new one is stored on the same edge. The bench provokes this with back-to-back read pairs and read-then-write pairs. Each answer is built either to carry the previous sub-address or to deliberately name the current one, so a design that compares against the freshly stored value reports the wrong status. Burst abort and acceptance of the next request also meet. A failing answer is followed immediately by a continuation request, which must already be skipped.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  localparam int FRAME_W = 16;
  localparam logic [4:0] READ_ADDR = 5'h10;
  localparam logic [7:0] NO_SUB    = 8'hFF;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_PARITY   = 2'd1,
    RSP_FRAME    = 2'd2,
    RSP_MISMATCH = 2'd3
  } rsp_status_e;

  // build an outgoing word with odd overall parity
  function automatic logic [FRAME_W-1:0] make_frame(input logic is_rd,
                                                    input logic [4:0] addr,
                                                    input logic [7:0] data);
    logic [FRAME_W-1:0] f;
    f = '0;
    if (is_rd) begin
      f[14:10] = READ_ADDR;
      f[5:1]   = addr;
    end else begin
      f[14:10] = addr;
      f[8:1]   = data;
    end
    f[0] = ~(^f[15:1]);
    return f;
  endfunction

  function automatic logic parity_is_odd(input logic [FRAME_W-1:0] w);
    return ^w;
  endfunction

  // verdict on an answer given the sub-address of the frame before it
  function automatic rsp_status_e judge_reply(input logic [FRAME_W-1:0] rx,
                                              input logic [7:0] prev_sub);
    if (!parity_is_odd(rx))
      return RSP_PARITY;
    if (rx[15])
      return RSP_FRAME;
    if (prev_sub != NO_SUB) begin
      if (!rx[9] || ({3'b000, rx[14:10]} != prev_sub))
        return RSP_MISMATCH;
    end
    return RSP_OK;
  endfunction

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_frame_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_CLKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] rx_word,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EDGES = 2 * FRAME_W;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int GW    = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {E_IDLE, E_SHIFT, E_GAP} eng_state_e;

  eng_state_e         st_q;
  logic [DIV_W-1:0]   div_q;
  logic [EW-1:0]      edge_q;
  logic [GW-1:0]      gap_q;
  logic [FRAME_W-1:0] tx_sr, rx_sr;
  logic               half_tick;
  logic               rising_evt, falling_evt, last_edge;

  assign half_tick   = (st_q == E_SHIFT) && (div_q == DIV_W'(HALF_DIV - 1));
  assign rising_evt  = half_tick && !edge_q[0];
  assign falling_evt = half_tick &&  edge_q[0];
  assign last_edge   = (edge_q == EW'(EDGES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= E_IDLE;
      div_q  <= '0;
      edge_q <= '0;
      gap_q  <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        E_IDLE: if (start) begin
          tx_sr  <= tx_word;
          cs_n   <= 1'b0;
          div_q  <= '0;
          edge_q <= '0;
          st_q   <= E_SHIFT;
        end
        E_SHIFT: begin
          div_q <= half_tick ? '0 : div_q + 1'b1;
          if (rising_evt) begin
            sclk <= 1'b1;
            if (edge_q != '0) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
          end
          if (falling_evt) begin
            sclk  <= 1'b0;
            rx_sr <= {rx_sr[FRAME_W-2:0], miso};
            if (last_edge) begin
              cs_n  <= 1'b1;
              gap_q <= '0;
              st_q  <= E_GAP;
            end
          end
          if (half_tick) edge_q <= edge_q + 1'b1;
        end
        E_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_q == GW'(GAP_CLKS - 1)) begin
            done <= 1'b1;
            st_q <= E_IDLE;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != E_IDLE);
  assign mosi    = tx_sr[FRAME_W-1];
  assign rx_word = rx_sr;

endmodule

// File: rtl/spi_reply_check.sv
module spi_reply_check
  import spi_frame_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chk_en,
  input  logic [FRAME_W-1:0] rx_word,
  input  logic               frame_is_read,
  input  logic [4:0]         frame_sub,
  output rsp_status_e        verdict,
  output logic [7:0]         prev_sub,
  output logic [CNT_W-1:0]   cnt_parity,
  output logic [CNT_W-1:0]   cnt_frame,
  output logic [CNT_W-1:0]   cnt_mismatch
);

  // verdict uses the sub-address stored by the frame before this one
  assign verdict = judge_reply(rx_word, prev_sub);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sub     <= NO_SUB;
      cnt_parity   <= '0;
      cnt_frame    <= '0;
      cnt_mismatch <= '0;
    end else if (chk_en) begin
      prev_sub <= frame_is_read ? {3'b000, frame_sub} : NO_SUB;
      case (verdict)
        RSP_PARITY:   if (cnt_parity   != '1) cnt_parity   <= cnt_parity   + 1'b1;
        RSP_FRAME:    if (cnt_frame    != '1) cnt_frame    <= cnt_frame    + 1'b1;
        RSP_MISMATCH: if (cnt_mismatch != '1) cnt_mismatch <= cnt_mismatch + 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_frame_xcvr.sv
module spi_frame_xcvr
  import spi_frame_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_CLKS = 2,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_read,
  input  logic             req_cont,
  input  logic [4:0]       req_addr,
  input  logic [7:0]       req_data,
  output logic             rsp_valid,
  output logic [15:0]      rsp_data,
  output logic [1:0]       rsp_status,
  output logic             rsp_skipped,
  output logic [CNT_W-1:0] cnt_parity,
  output logic [CNT_W-1:0] cnt_frame,
  output logic [CNT_W-1:0] cnt_mismatch,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  logic               eng_busy, eng_done;
  logic [FRAME_W-1:0] eng_rx;
  logic               accept, skip_req, start_frame;
  logic               cur_read_q, burst_fail_q;
  logic [4:0]         cur_sub_q;
  logic [7:0]         prev_sub;
  rsp_status_e        verdict;

  assign req_ready   = !eng_busy && !eng_done && !rsp_valid;
  assign accept      = req_valid && req_ready;
  assign skip_req    = accept && req_cont && burst_fail_q;
  assign start_frame = accept && !skip_req;

  spi_shift_engine #(.HALF_DIV(HALF_DIV), .GAP_CLKS(GAP_CLKS)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start_frame),
    .tx_word (make_frame(req_is_read, req_addr, req_data)),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_word (eng_rx),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .mosi    (mosi),
    .miso    (miso)
  );

  spi_reply_check #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .chk_en        (eng_done),
    .rx_word       (eng_rx),
    .frame_is_read (cur_read_q),
    .frame_sub     (cur_sub_q),
    .verdict       (verdict),
    .prev_sub      (prev_sub),
    .cnt_parity    (cnt_parity),
    .cnt_frame     (cnt_frame),
    .cnt_mismatch  (cnt_mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_read_q   <= 1'b0;
      cur_sub_q    <= '0;
      burst_fail_q <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      rsp_status   <= '0;
      rsp_skipped  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && !req_cont) burst_fail_q <= 1'b0;
      if (start_frame) begin
        cur_read_q <= req_is_read;
        cur_sub_q  <= req_addr;
      end
      if (skip_req) begin
        rsp_valid   <= 1'b1;
        rsp_data    <= '0;
        rsp_status  <= RSP_OK;
        rsp_skipped <= 1'b1;
      end
      if (eng_done) begin
        rsp_valid   <= 1'b1;
        rsp_data    <= eng_rx;
        rsp_status  <= verdict;
        rsp_skipped <= 1'b0;
        if (verdict != RSP_OK) burst_fail_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_frame_xcvr_chk.sv
module spi_frame_xcvr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic             rsp_skipped,
  input logic [CNT_W-1:0] cnt_parity,
  input logic [CNT_W-1:0] cnt_mismatch,
  input logic [7:0]       prev_sub,
  input logic             sclk,
  input logic             cs_n
);

  // R4: clock stays low outside a frame
  a_r4_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R5: no request taken while the frame is on the wire
  a_r5_ready_blocked: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !req_ready);

  // R5: completion is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6: a parity verdict is accompanied by a counter step
  a_r6_parity_count: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_skipped && rsp_status == 2'd1 && $past(cnt_parity) != '1)
      |-> cnt_parity == $past(cnt_parity) + 1'b1);

  // R8: a mismatch verdict is accompanied by a counter step
  a_r8_mismatch_count: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_skipped && rsp_status == 2'd3 && $past(cnt_mismatch) != '1)
      |-> cnt_mismatch == $past(cnt_mismatch) + 1'b1);

  // R10: a skipped request leaves the bus and check state alone
  a_r10_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_skipped) |-> (cs_n && rsp_status == 2'd0 && $stable(prev_sub)));

  // R12: a full counter holds
  a_r12_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt_parity == '1) |=> (cnt_parity == '1));

endmodule

bind spi_frame_xcvr spi_frame_xcvr_chk #(.CNT_W(CNT_W)) u_xcvr_chk (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_status   (rsp_status),
  .rsp_skipped  (rsp_skipped),
  .cnt_parity   (cnt_parity),
  .cnt_mismatch (cnt_mismatch),
  .prev_sub     (prev_sub),
  .sclk         (sclk),
  .cs_n         (cs_n)
);

// File: tb/spi_frame_xcvr_test.sv
`timescale 1ns/1ps
module spi_frame_xcvr_test;

  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_is_read = 1'b0, req_cont = 1'b0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_skipped, sclk, cs_n, mosi;
  logic miso = 1'b0;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_status;
  logic [CW-1:0] cnt_parity, cnt_frame, cnt_mismatch;

  always #10 clk = ~clk;

  spi_frame_xcvr #(.HALF_DIV(2), .GAP_CLKS(2), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_read(req_is_read), .req_cont(req_cont), .req_addr(req_addr),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_status(rsp_status), .rsp_skipped(rsp_skipped),
    .cnt_parity(cnt_parity), .cnt_frame(cnt_frame), .cnt_mismatch(cnt_mismatch),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [15:0] slv_reply = '0;
  logic [15:0] mosi_cap = '0;
  int bit_idx = 0, rises = 0, frames = 0;
  int gap_cnt = 0, min_gap = 1000;

  always @(negedge cs_n) begin
    bit_idx = 0; rises = 0; mosi_cap = '0; frames++;
    if (frames > 1 && gap_cnt < min_gap) min_gap = gap_cnt;
  end
  always @(posedge sclk) begin
    miso = slv_reply[15 - bit_idx];
    rises++;
  end
  always @(negedge sclk) begin
    mosi_cap = {mosi_cap[14:0], mosi};
    bit_idx++;
  end
  always @(posedge clk) begin
    if (cs_n) gap_cnt <= gap_cnt + 1; else gap_cnt <= 0;
  end

  // ---------------- reference model ----------------
  logic [7:0] m_prev = 8'hFF;
  bit m_fail = 0;
  int m_cp = 0, m_cf = 0, m_cm = 0;
  localparam int CMAX = (1 << CW) - 1;

  function automatic logic [15:0] ref_frame(bit rd, logic [4:0] a, logic [7:0] d);
    logic [15:0] w;
    if (rd) w = {1'b0, 5'b10000, 1'b0, 3'b000, a, 1'b0};
    else    w = {1'b0, a, 1'b0, d, 1'b0};
    if ($countones(w) % 2 == 0) w[0] = 1'b1;
    return w;
  endfunction

  function automatic int ref_status(logic [15:0] r, logic [7:0] prev);
    if ($countones(r) % 2 == 0) return 1;
    if (r[15] == 1'b1) return 2;
    if (prev != 8'hFF && (r[9] != 1'b1 || r[14:10] != prev[4:0])) return 3;
    return 0;
  endfunction

  // answer with odd parity, given header fields
  function automatic logic [15:0] fix_odd(logic [15:0] r);
    logic [15:0] w = {r[15:1], 1'b0};
    if ($countones(w) % 2 == 0) w[0] = 1'b1;
    return w;
  endfunction

  function automatic logic [15:0] good_reply(logic [7:0] prev, logic [7:0] d);
    logic [4:0] a = (prev == 8'hFF) ? 5'h07 : prev[4:0];
    return fix_odd({1'b0, a, 1'b1, d, 1'b0});
  endfunction

  task automatic send(input bit rd, input logic [4:0] a, input logic [7:0] d,
                      input bit cont, input logic [15:0] reply, input string tag);
    int fr0, w, est;
    bit exp_skip;
    @(negedge clk);
    w = 0;
    while (!req_ready && w < 500) begin @(negedge clk); w++; end
    exp_skip = cont && m_fail;
    if (!cont) m_fail = 0;
    slv_reply = reply;
    fr0 = frames;
    req_valid = 1; req_is_read = rd; req_addr = a; req_data = d; req_cont = cont;
    @(negedge clk);
    req_valid = 0;
    w = 0;
    while (!rsp_valid && w < 500) begin @(negedge clk); w++; end
    chk(rsp_valid, {tag, " R5 rsp_valid"}, rsp_valid, 1);
    chk(rsp_skipped == exp_skip, {tag, " R10 skipped"}, rsp_skipped, exp_skip);
    if (exp_skip) begin
      chk(frames == fr0, {tag, " R10 no cs"}, frames, fr0);
      chk(rsp_status == 0, {tag, " R10 status"}, rsp_status, 0);
    end else begin
      est = ref_status(reply, m_prev);
      chk(mosi_cap == ref_frame(rd, a, d), {tag, rd ? " R3 frame" : " R1 R2 frame"},
          mosi_cap, ref_frame(rd, a, d));
      chk(rises == 16, {tag, " R4 sclk count"}, rises, 16);
      chk(rsp_data == reply, {tag, " R5 data"}, rsp_data, reply);
      chk(rsp_status == est, {tag, " R8 status"}, rsp_status, est);
      if (est == 1 && m_cp < CMAX) m_cp++;
      if (est == 2 && m_cf < CMAX) m_cf++;
      if (est == 3 && m_cm < CMAX) m_cm++;
      if (est != 0) m_fail = 1;
      m_prev = rd ? {3'b000, a} : 8'hFF;
    end
    @(negedge clk);
    chk(rsp_valid == 0, {tag, " R5 pulse"}, rsp_valid, 0);
    chk(cnt_parity == m_cp, {tag, " R6 R12 cnt_parity"}, cnt_parity, m_cp);
    chk(cnt_frame == m_cf, {tag, " R7 cnt_frame"}, cnt_frame, m_cf);
    chk(cnt_mismatch == m_cm, {tag, " R8 cnt_mismatch"}, cnt_mismatch, m_cm);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(cnt_parity == 0 && cnt_frame == 0 && cnt_mismatch == 0, "R11 counters", cnt_parity, 0);
    chk(req_ready == 1 && cs_n == 1 && sclk == 0, "R11 idle", {req_ready, cs_n, sclk}, 3'b110);
    // R11 / R9: first answer not address-checked even if header is odd
    send(0, 5'h0A, 8'hA5, 0, fix_odd(16'h7C00), "R11 first");
    // R9: write then odd-header answer passes
    send(0, 5'h1F, 8'h00, 0, fix_odd(16'h0400), "R9 after write");
    // R6 parity
    send(0, 5'h03, 8'hFF, 0, 16'h0003, "R6 even");
    // R7 frame error
    send(0, 5'h04, 8'h3C, 0, fix_odd(16'h8000), "R7 bit15");
    // R3 read, then read: answer must name first sub-address
    send(1, 5'h12, 8'hEE, 0, good_reply(8'hFF, 8'h11), "R3 read a");
    send(1, 5'h05, 8'h00, 0, good_reply(8'h12, 8'h22), "R8 ok");
    // R8 answer names the current (not previous) sub-address
    send(1, 5'h09, 8'h00, 0, fix_odd({1'b0, 5'h09, 1'b1, 9'h0}), "R8 wrong addr");
    // R8 bit 9 clear
    send(0, 5'h01, 8'h01, 0, fix_odd({1'b0, 5'h09, 1'b0, 9'h0}), "R8 no wr bit");
    // R10 burst: fail then skip, then new burst
    send(0, 5'h02, 8'h10, 0, 16'h0000, "R10 fail");
    send(1, 5'h06, 8'h00, 1, good_reply(8'hFF, 8'h00), "R10 skip1");
    send(0, 5'h07, 8'h00, 1, good_reply(8'hFF, 8'h00), "R10 skip2");
    send(0, 5'h08, 8'h42, 0, good_reply(8'hFF, 8'h5A), "R10 new burst");
    send(1, 5'h0B, 8'h00, 1, good_reply(8'hFF, 8'h5A), "R10 cont ok");
    send(0, 5'h0C, 8'h77, 1, good_reply(8'h0B, 8'h01), "R10 cont ok2");
    // R12 saturation of parity counter
    for (int i = 0; i < 18; i++) send(0, 5'(i), 8'(i), 0, 16'h0101, "R12 sat");
    // random mix
    for (int i = 0; i < 150; i++) begin
      bit rd = $urandom_range(0, 1);
      bit ct = ($urandom_range(0, 3) == 0);
      logic [15:0] rp;
      int kind = $urandom_range(0, 9);
      if (kind < 6) rp = good_reply(m_prev, 8'($urandom));
      else if (kind == 6) rp = 16'($urandom) & 16'hFFFE;
      else if (kind == 7) rp = fix_odd(16'($urandom) | 16'h8000);
      else rp = fix_odd(16'($urandom) & 16'h7FFF);
      send(rd, 5'($urandom), 8'($urandom), ct, rp, "R8 random");
    end
    chk(min_gap >= 2, "R4 cs gap", min_gap, 2);
    finish_run();
  end

endmodule